// File: doc/BRIEF.md
# Byte-Lane Static RAM Controller

This block is the control and data path of a word-organised static RAM with two 8-bit byte lanes, modelled on a sampling clock. Two chip selects of opposite polarity, an active-low write enable, an active-low output enable and two active-low lane enables are decoded into per-lane write strobes for an internal storage array. They also drive per-lane output-drive enables for a shared 16-bit data bus and a standby flag. The bus is split into a data-in vector, a data-out vector and one drive enable per lane. An enclosing pad ring can merge these into a tristate bus, and the block itself needs no internal tristates.

A write is committed to the array at the clock edge that samples it. Read data, drive enables and standby are combinational from the inputs and the array contents. A mode input makes the same storage look like twice as many byte-wide words. In that mode the lowest address bit picks a half of the stored word, and only the low eight data lines carry data. The word-address width is a parameter. Simulation uses a small array, and a full-size part would use a 20-bit word address.

Top module: `sram_lane_ctrl`

## Requirements
- R1: The part is selected only when `sel_n_i` is 0 and `sel_i` is 1. No other combination can drive the bus or modify the array.
- R2: `standby_o` is 1 when the part is deselected, or when both `lane_n_i` bits are 1. While it is 1, `drive_o` is 0 and no stored bit changes.
- R3: In word mode (`byte_mode_i`=0), a selected cycle with `we_n_i`=0 stores `wdata_i[7:0]` into bits 7:0 of the addressed word if `lane_n_i[0]`=0. It stores `wdata_i[15:8]` into bits 15:8 if `lane_n_i[1]`=0. A disabled lane keeps its old value.
- R4: In word mode, a selected cycle with `oe_n_i`=0 and `we_n_i`=1 sets `drive_o[i]` to 1 exactly for each lane whose `lane_n_i[i]` is 0. That lane of `rdata_o` carries the stored byte, and undriven lanes of `rdata_o` read 0.
- R5: Write priority: whenever a write is active, `drive_o` is 0 even if `oe_n_i` is 0.
- R6: A selected cycle with `we_n_i`=1 and `oe_n_i`=1 drives nothing and changes nothing.
- R7: In byte mode (`byte_mode_i`=1), the word index is `addr_i[AW:1]`. `addr_i[0]`=0 selects bits 7:0 and `addr_i[0]`=1 selects bits 15:8. A write stores `wdata_i[7:0]` into the selected half only, provided at least one lane enable is 0.
- R8: A byte-mode read sets `drive_o` to 2'b01 and returns the selected half on `rdata_o[7:0]`, with `rdata_o[15:8]` reading 0.
- R9: In word mode the word index is `addr_i[AW-1:0]`, and `addr_i[AW]` has no effect.
- R10: A clock edge with `rst` high clears every stored word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset, clears the array |
| sel_n_i | input | 1 | Active-low chip select |
| sel_i | input | 1 | Active-high chip select |
| we_n_i | input | 1 | Active-low write enable |
| oe_n_i | input | 1 | Active-low output enable |
| lane_n_i | input | 2 | Active-low lane enables, bit 0 for data 7:0 and bit 1 for data 15:8 |
| byte_mode_i | input | 1 | 1 selects the byte-wide organisation |
| addr_i | input | AW+1 | Address, where bit 0 selects the half in byte mode |
| wdata_i | input | 16 | Bus data into the part |
| rdata_o | output | 16 | Bus data out of the part, 0 on undriven lanes |
| drive_o | output | 2 | Per-lane output drive enable |
| standby_o | output | 1 | Standby indication |

## Verification
The bench targets write-with-output-enable cycles. A design that let output enable win would drive stale data onto the bus while it is being written. Single-lane writes followed by full-word reads expose a strobe that leaks into the other lane. Writes under each deselect pattern and under both lane enables high expose a select decode that accepts half a select, or a standby that still writes. Byte-mode accesses to both halves, and word accesses with the spare top address bit set, catch wrong half steering and address aliasing. A mid-run reset must leave every read at zero.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int BUS_W  = LANE_W * LANES;

    typedef logic [LANES-1:0] lane_mask_t;
    typedef logic [BUS_W-1:0] bus_word_t;

    typedef enum logic [1:0] {
        ACC_STANDBY,
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE
    } acc_op_e;

    typedef struct packed {
        acc_op_e    op;
        lane_mask_t lanes;
    } acc_ctrl_t;

    function automatic logic chip_selected(input logic sel_n, input logic sel);
        return !sel_n && sel;
    endfunction

    function automatic lane_mask_t half_mask(input logic upper);
        return upper ? lane_mask_t'(2'b10) : lane_mask_t'(2'b01);
    endfunction

endpackage

// File: rtl/sram_acc_decode.sv
module sram_acc_decode
    import sram_lane_pkg::*;
(
    input  logic       sel_n,
    input  logic       sel,
    input  logic       we_n,
    input  logic       oe_n,
    input  lane_mask_t lane_n,
    output acc_ctrl_t  ctrl,
    output logic       standby
);

    logic selected;
    logic lanes_off;

    always_comb begin
        selected   = chip_selected(sel_n, sel);
        lanes_off  = &lane_n;
        standby    = !selected || lanes_off;
        ctrl.lanes = ~lane_n;
        if (standby)
            ctrl.op = ACC_STANDBY;
        else if (!we_n)
            ctrl.op = ACC_WRITE;
        else if (!oe_n)
            ctrl.op = ACC_READ;
        else
            ctrl.op = ACC_IDLE;
    end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array
    import sram_lane_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  lane_mask_t    wr_strobe,
    input  bus_word_t     wr_data,
    output bus_word_t     rd_word
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++)
                    bank[i] <= '0;
            end else if (wr_strobe[g]) begin
                bank[addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = bank[addr];
    end

    // R3: a word with no strobe keeps its value across the edge
    a_r3_hold_unstrobed: assert property (@(posedge clk) disable iff (rst)
        (wr_strobe == '0) |=> ($stable(addr) -> $stable(rd_word)));

    // R10: reset leaves zero behind
    a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_word == '0));

endmodule

// File: rtl/sram_byte_steer.sv
module sram_byte_steer
    import sram_lane_pkg::*;
#(
    parameter int AW = 8
) (
    input  acc_ctrl_t     ctrl,
    input  logic          byte_mode,
    input  logic [AW:0]   addr,
    input  bus_word_t     wdata,
    input  bus_word_t     rd_word,
    output logic [AW-1:0] word_addr,
    output lane_mask_t    wr_strobe,
    output bus_word_t     wr_data,
    output lane_mask_t    drive,
    output bus_word_t     rdata
);

    logic upper;

    always_comb begin
        upper     = addr[0];
        word_addr = byte_mode ? addr[AW:1] : addr[AW-1:0];
        wr_data   = byte_mode ? {LANES{wdata[LANE_W-1:0]}} : wdata;
        wr_strobe = '0;
        drive     = '0;
        rdata     = '0;
        case (ctrl.op)
            ACC_WRITE: wr_strobe = byte_mode ? half_mask(upper) : ctrl.lanes;
            ACC_READ: begin
                if (byte_mode) begin
                    drive              = lane_mask_t'(1);
                    rdata[LANE_W-1:0]  = upper ? rd_word[BUS_W-1:LANE_W]
                                               : rd_word[LANE_W-1:0];
                end else begin
                    drive = ctrl.lanes;
                    for (int i = 0; i < LANES; i++)
                        if (ctrl.lanes[i])
                            rdata[i*LANE_W +: LANE_W] = rd_word[i*LANE_W +: LANE_W];
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_n_i,
    input  logic          sel_i,
    input  logic          we_n_i,
    input  logic          oe_n_i,
    input  logic [1:0]    lane_n_i,
    input  logic          byte_mode_i,
    input  logic [AW:0]   addr_i,
    input  logic [15:0]   wdata_i,
    output logic [15:0]   rdata_o,
    output logic [1:0]    drive_o,
    output logic          standby_o
);

    acc_ctrl_t     ctrl;
    logic [AW-1:0] word_addr;
    lane_mask_t    wr_strobe;
    bus_word_t     wr_data;
    bus_word_t     rd_word;

    sram_acc_decode u_decode (
        .sel_n   (sel_n_i),
        .sel     (sel_i),
        .we_n    (we_n_i),
        .oe_n    (oe_n_i),
        .lane_n  (lane_n_i),
        .ctrl    (ctrl),
        .standby (standby_o)
    );

    sram_byte_steer #(.AW(AW)) u_steer (
        .ctrl      (ctrl),
        .byte_mode (byte_mode_i),
        .addr      (addr_i),
        .wdata     (wdata_i),
        .rd_word   (rd_word),
        .word_addr (word_addr),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .drive     (drive_o),
        .rdata     (rdata_o)
    );

    sram_lane_array #(.AW(AW)) u_array (
        .clk       (clk),
        .rst       (rst),
        .addr      (word_addr),
        .wr_strobe (wr_strobe),
        .wr_data   (wr_data),
        .rd_word   (rd_word)
    );

    // R1: nothing drives or writes without a full select
    a_r1_select_gates: assert property (@(posedge clk) disable iff (rst)
        ((drive_o != '0) || (wr_strobe != '0)) |-> (!sel_n_i && sel_i));

    // R2: standby is quiet on the bus and the array
    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        standby_o |-> ((drive_o == '0) && (wr_strobe == '0)));

    // R5: write wins over output enable
    a_r5_write_no_drive: assert property (@(posedge clk) disable iff (rst)
        (!we_n_i && !standby_o) |-> ((drive_o == '0) && (wr_strobe != '0)));

    // R6: output enable off never drives
    a_r6_oe_off_no_drive: assert property (@(posedge clk) disable iff (rst)
        oe_n_i |-> (drive_o == '0));

    // R8: byte mode uses only the low lane
    a_r8_byte_low_lane: assert property (@(posedge clk) disable iff (rst)
        byte_mode_i |-> (!drive_o[1] && (rdata_o[15:8] == '0)));

endmodule

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;

    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1, sel = 1'b0, we_n = 1'b1, oe_n = 1'b1;
    logic [1:0]    lane_n = 2'b11;
    logic          bmode = 1'b0;
    logic [AW:0]   addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic [1:0]    drive;
    logic          standby;

    logic [15:0]   mdl [DEPTH];
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(.AW(AW)) u_sram_lane_ctrl (
        .clk(clk), .rst(rst), .sel_n_i(sel_n), .sel_i(sel), .we_n_i(we_n),
        .oe_n_i(oe_n), .lane_n_i(lane_n), .byte_mode_i(bmode), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .drive_o(drive), .standby_o(standby)
    );

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // one cycle: drive, check mid-cycle against the model, then advance the model
    task automatic cyc(input logic csn, input logic cs, input logic wen, input logic oen,
                       input logic [1:0] ln, input logic bm, input logic [AW:0] a,
                       input logic [15:0] d, input string tag);
        logic        on, quiet;
        logic [1:0]  e_drv;
        logic [15:0] e_rd, w;
        int          idx;
        string       t;
        @(negedge clk);
        sel_n = csn; sel = cs; we_n = wen; oe_n = oen; lane_n = ln;
        bmode = bm; addr = a; wdata = d;
        #1;
        on    = !csn && cs;
        quiet = !on || (ln == 2'b11);
        idx   = bm ? int'(a[AW:1]) : int'(a[AW-1:0]);
        w     = mdl[idx];
        e_drv = 2'b00;
        e_rd  = 16'h0000;
        if (!quiet && wen && !oen) begin
            if (bm) begin
                e_drv = 2'b01;
                e_rd  = {8'h00, a[0] ? w[15:8] : w[7:0]};
            end else begin
                e_drv = ~ln;
                e_rd  = {e_drv[1] ? w[15:8] : 8'h00, e_drv[0] ? w[7:0] : 8'h00};
            end
        end
        if (tag != "") t = tag;
        else if (quiet) t = "R2";
        else if (!wen) t = bm ? "R7" : (oen ? "R3" : "R5");
        else if (!oen) t = bm ? "R8" : "R4";
        else t = "R6";
        checks++;
        if (drive !== e_drv || rdata !== e_rd || standby !== quiet) begin
            errors++;
            $display("FAIL %s addr=%h: got drive=%b rdata=%h standby=%b, expected drive=%b rdata=%h standby=%b",
                     t, a, drive, rdata, standby, e_drv, e_rd, quiet);
        end
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mdl[i] = 16'h0000;
        end else if (!quiet && !wen) begin
            if (bm) begin
                if (a[0]) mdl[idx][15:8] = d[7:0];
                else      mdl[idx][7:0]  = d[7:0];
            end else begin
                if (!ln[0]) mdl[idx][7:0]  = d[7:0];
                if (!ln[1]) mdl[idx][15:8] = d[15:8];
            end
        end
    endtask

    task automatic rd_word(input logic [AW:0] a, input string tag);
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, a, 16'hFFFF, tag);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mdl[i] = 16'h0000;
        repeat (2) cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, '0, '0, "R10");
        rst = 1'b0;
        // R10: array reads zero after reset
        rd_word(9'h000, "R10");
        rd_word(9'h0FF, "R10");
        // R3: full and single-lane word writes
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 9'h010, 16'hA55A, "R3");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 9'h010, 16'h1234, "R3");
        rd_word(9'h010, "R3");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 9'h010, 16'hBEEF, "R3");
        rd_word(9'h010, "R3");
        // R4: per-lane reads
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 9'h010, '0, "R4");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b0, 9'h010, '0, "R4");
        // R5: write with output enable low
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 9'h020, 16'h7E81, "R5");
        rd_word(9'h020, "R5");
        // R6: idle selected cycle
        cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 9'h020, 16'h0000, "R6");
        // R1: partial selects do not write
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 9'h020, 16'h0000, "R1");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 9'h020, 16'h0000, "R1");
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 9'h020, 16'h0000, "R1");
        rd_word(9'h020, "R1");
        // R2: both lanes off is standby even with a write
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 9'h020, 16'h0000, "R2");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b0, 9'h020, 16'h0000, "R2");
        rd_word(9'h020, "R2");
        // R9: top address bit ignored in word mode
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b0, 9'h105, 16'hC3D2, "R9");
        rd_word(9'h005, "R9");
        // R7, R8: byte mode halves
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 9'h041, 16'h0099, "R7");
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 1'b1, 9'h040, 16'hFF66, "R7");
        rd_word(9'h020, "R7");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b1, 9'h041, '0, "R8");
        cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b1, 9'h040, '0, "R8");
        // mixed traffic on a small address window
        begin
            logic [31:0] lf = 32'hACE1_1234;
            for (int n = 0; n < 3000; n++) begin
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                cyc(lf[3] & lf[4], lf[5] | lf[6], lf[7], lf[8], lf[10:9], lf[11],
                    {lf[12], 4'b0000, lf[16:13]}, lf[31:16], "");
            end
        end
        // R10: reset in mid-run clears written words
        rst = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, '0, '0, "R10");
        rst = 1'b0;
        rd_word(9'h010, "R10");
        rd_word(9'h020, "R10");
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        summary();
        $finish;
    end

endmodule